// File: doc/BRIEF.md
# Banked Program Page Address Mapper

This block turns a 16-bit local CPU address into a 22-bit global program-memory address. The upper two bits of the local address pick one of four 16K windows. The lower 14 bits pass through unchanged as the page offset. The global address is the 8-bit page number placed in front of the 14-bit offset.

The windows are mapped as follows:
- The lowest window never maps to program memory.
- The second window maps to a fixed page, but only while a high-mapping control input is low. When that input is high, the window is released.
- The third window is the banked window. Its page number comes from a writable 8-bit page index register.
- The top window always maps to a second fixed page.

The page index register resets to the page between the two fixed pages. Out of reset, local addresses 0x4000 through 0xFFFF therefore form one linear stretch of program memory. Software can read or write the register at any time. A write changes the translation from the next clock edge onward, and the translation itself is purely combinational.

Top module: `ppm_page_mapper`

## Requirements
- R1: After reset, the page index register reads 0xFE on `pg_rd_data`.
- R2: A local address with bits [15:14] = 00 gives `glob_hit` = 0 and `glob_addr` = 0.
- R3: A local address with bits [15:14] = 01, while `rom_hi_remap` = 0, gives `glob_hit` = 1 and global page (`glob_addr[21:14]`) = 0xFD.
- R4: A local address with bits [15:14] = 01, while `rom_hi_remap` = 1, gives `glob_hit` = 0 and `glob_addr` = 0.
- R5: A local address with bits [15:14] = 11 gives `glob_hit` = 1 and global page 0xFF, whatever `rom_hi_remap` and the page register hold.
- R6: A local address with bits [15:14] = 10 gives `glob_hit` = 1 and a global page equal to the page index register.
- R7: Whenever `glob_hit` = 1, `glob_addr[13:0]` equals `loc_addr[13:0]`.
- R8: When `pg_wr_en` = 1 at a rising clock edge, `pg_wr_data` becomes the register value after that edge. Before that edge, the translation still uses the old value.
- R9: Without `pg_wr_en`, the page index register keeps its value across clock edges.
- R10: Out of reset with `rom_hi_remap` = 0, every local address A in 0x4000..0xFFFF maps to global address 0x3F4000 + (A − 0x4000), with `glob_hit` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| loc_addr | input | 16 | Local CPU address |
| rom_hi_remap | input | 1 | 1 releases the 0x4000–0x7FFF window from program memory |
| pg_wr_en | input | 1 | Page index register write strobe |
| pg_wr_data | input | 8 | Page index write value |
| pg_rd_data | output | 8 | Current page index register value |
| glob_addr | output | 22 | Global address {page, offset}, zero on a miss |
| glob_hit | output | 1 | Local address falls in a mapped window |

## Verification
The bench sweeps all 65536 local addresses out of reset, once with the high-mapping control low and once with it high. This sweep catches three kinds of error:
- A decoder that lets the bottom window hit, or that ignores the control input in the second window.
- A reset value other than 0xFE, which breaks the linear span at the 0x8000 or 0xC000 boundary.
- An offset taken from the wrong bits, which repeats or scrambles addresses inside a window.

The bench also writes all 256 page values. For each one it checks the following:
- The banked window still shows the old page while the strobe is up.
- It shows the new page right after the edge.
- It keeps that page through idle edges.
- The two fixed windows never follow the register.

A register that loads too early, too late or without the strobe shows up as a wrong page number in the banked window.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

  // Role of each local-address window
  typedef enum logic [1:0] {
    WK_UNMAPPED      = 2'd0,
    WK_FIXED_SWITCH  = 2'd1,
    WK_BANKED        = 2'd2,
    WK_FIXED         = 2'd3
  } win_kind_e;

  // Window 0 unmapped, window 1 switchable fixed, top window fixed,
  // all windows in between banked.
  function automatic win_kind_e win_kind(input int idx, input int num_win);
    win_kind_e k;
    if (idx == 0)                k = WK_UNMAPPED;
    else if (idx == num_win - 1) k = WK_FIXED;
    else if (idx == 1)           k = WK_FIXED_SWITCH;
    else                         k = WK_BANKED;
    return k;
  endfunction

endpackage

// File: rtl/ppm_rst_sync.sv
module ppm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_d;
  logic [STAGES-1:0] sync_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/ppm_page_reg.sv
module ppm_page_reg #(
  parameter int PAGE_W     = 8,
  parameter int RESET_PAGE = 8'hFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_data,
  output logic [PAGE_W-1:0] page_q
);

  localparam logic [PAGE_W-1:0] RST_VAL = PAGE_W'(RESET_PAGE);

  logic [PAGE_W-1:0] page_d;
  logic [PAGE_W-1:0] page_r;

  always_comb begin
    page_d = page_r;
    if (wr_en) page_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     page_r <= RST_VAL;
    else if (wr_en) page_r <= page_d;
  end

  assign page_q = page_r;

endmodule

// File: rtl/ppm_window_decode.sv
module ppm_window_decode #(
  parameter int LOCAL_AW        = 16,
  parameter int OFFSET_W        = 14,
  parameter int PAGE_W          = 8,
  parameter int LOW_FIXED_PAGE  = 8'hFD,
  parameter int HIGH_FIXED_PAGE = 8'hFF
) (
  input  logic [LOCAL_AW-1:0] loc_addr,
  input  logic                hi_remap,
  input  logic [PAGE_W-1:0]   bank_page,
  output logic                hit,
  output logic [PAGE_W-1:0]   page
);

  localparam int SEL_W   = LOCAL_AW - OFFSET_W;
  localparam int NUM_WIN = 1 << SEL_W;

  logic [SEL_W-1:0]   sel;
  logic [NUM_WIN-1:0] win_act;
  logic [NUM_WIN-1:0] win_map;
  logic [PAGE_W-1:0]  win_page [NUM_WIN];

  assign sel = loc_addr[LOCAL_AW-1:OFFSET_W];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    localparam ppm_pkg::win_kind_e KIND = ppm_pkg::win_kind(g, NUM_WIN);
    assign win_act[g] = (sel == SEL_W'(g));
    if (KIND == ppm_pkg::WK_UNMAPPED) begin : g_none
      assign win_map[g]  = 1'b0;
      assign win_page[g] = '0;
    end else if (KIND == ppm_pkg::WK_FIXED_SWITCH) begin : g_sw
      assign win_map[g]  = ~hi_remap;
      assign win_page[g] = PAGE_W'(LOW_FIXED_PAGE);
    end else if (KIND == ppm_pkg::WK_BANKED) begin : g_bank
      assign win_map[g]  = 1'b1;
      assign win_page[g] = bank_page;
    end else begin : g_fix
      assign win_map[g]  = 1'b1;
      assign win_page[g] = PAGE_W'(HIGH_FIXED_PAGE);
    end
  end

  // One-hot select over windows
  always_comb begin
    hit  = 1'b0;
    page = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (win_act[i] && win_map[i]) begin
        hit  = 1'b1;
        page = win_page[i];
      end
    end
  end

endmodule

// File: rtl/ppm_addr_compose.sv
module ppm_addr_compose #(
  parameter int LOCAL_AW = 16,
  parameter int OFFSET_W = 14,
  parameter int PAGE_W   = 8
) (
  input  logic [LOCAL_AW-1:0]        loc_addr,
  input  logic                       hit,
  input  logic [PAGE_W-1:0]          page,
  output logic [PAGE_W+OFFSET_W-1:0] glob_addr
);

  always_comb begin
    glob_addr = '0;
    if (hit) glob_addr = {page, loc_addr[OFFSET_W-1:0]};
  end

endmodule

// File: rtl/ppm_page_mapper.sv
module ppm_page_mapper #(
  parameter int LOCAL_AW        = 16,
  parameter int OFFSET_W        = 14,
  parameter int PAGE_W          = 8,
  parameter int RESET_PAGE      = 8'hFE,
  parameter int LOW_FIXED_PAGE  = 8'hFD,
  parameter int HIGH_FIXED_PAGE = 8'hFF,
  parameter int SYNC_STAGES     = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LOCAL_AW-1:0]        loc_addr,
  input  logic                       rom_hi_remap,
  input  logic                       pg_wr_en,
  input  logic [PAGE_W-1:0]          pg_wr_data,
  output logic [PAGE_W-1:0]          pg_rd_data,
  output logic [PAGE_W+OFFSET_W-1:0] glob_addr,
  output logic                       glob_hit
);

  logic              rst_sync_n;
  logic [PAGE_W-1:0] bank_page;
  logic [PAGE_W-1:0] sel_page;
  logic              sel_hit;

  ppm_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  ppm_page_reg #(.PAGE_W(PAGE_W), .RESET_PAGE(RESET_PAGE)) i_page_reg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (pg_wr_en),
    .wr_data (pg_wr_data),
    .page_q  (bank_page)
  );

  ppm_window_decode #(
    .LOCAL_AW        (LOCAL_AW),
    .OFFSET_W        (OFFSET_W),
    .PAGE_W          (PAGE_W),
    .LOW_FIXED_PAGE  (LOW_FIXED_PAGE),
    .HIGH_FIXED_PAGE (HIGH_FIXED_PAGE)
  ) i_decode (
    .loc_addr  (loc_addr),
    .hi_remap  (rom_hi_remap),
    .bank_page (bank_page),
    .hit       (sel_hit),
    .page      (sel_page)
  );

  ppm_addr_compose #(
    .LOCAL_AW (LOCAL_AW),
    .OFFSET_W (OFFSET_W),
    .PAGE_W   (PAGE_W)
  ) i_compose (
    .loc_addr  (loc_addr),
    .hit       (sel_hit),
    .page      (sel_page),
    .glob_addr (glob_addr)
  );

  assign glob_hit   = sel_hit;
  assign pg_rd_data = bank_page;

endmodule

// File: rtl/ppm_page_mapper_chk.sv
module ppm_page_mapper_chk #(
  parameter int LOCAL_AW        = 16,
  parameter int OFFSET_W        = 14,
  parameter int PAGE_W          = 8,
  parameter int LOW_FIXED_PAGE  = 8'hFD,
  parameter int HIGH_FIXED_PAGE = 8'hFF
) (
  input logic                       clk,
  input logic                       srst_n,
  input logic [LOCAL_AW-1:0]        loc_addr,
  input logic                       rom_hi_remap,
  input logic                       pg_wr_en,
  input logic [PAGE_W-1:0]          pg_wr_data,
  input logic [PAGE_W-1:0]          pg_rd_data,
  input logic [PAGE_W+OFFSET_W-1:0] glob_addr,
  input logic                       glob_hit
);

  localparam int SEL_W   = LOCAL_AW - OFFSET_W;
  localparam int NUM_WIN = 1 << SEL_W;

  logic [SEL_W-1:0]  win;
  logic [PAGE_W-1:0] gpage;
  assign win   = loc_addr[LOCAL_AW-1:OFFSET_W];
  assign gpage = glob_addr[PAGE_W+OFFSET_W-1:OFFSET_W];

  assert_bottom_miss_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (win == SEL_W'(0)) |-> (!glob_hit && glob_addr == '0));

  assert_low_fixed_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (win == SEL_W'(1) && !rom_hi_remap) |-> (glob_hit && gpage == PAGE_W'(LOW_FIXED_PAGE)));

  assert_low_released_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (win == SEL_W'(1) && rom_hi_remap) |-> !glob_hit);

  assert_high_fixed_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (win == SEL_W'(NUM_WIN-1)) |-> (glob_hit && gpage == PAGE_W'(HIGH_FIXED_PAGE)));

  assert_banked_page_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (win == SEL_W'(2)) |-> (glob_hit && gpage == pg_rd_data));

  assert_offset_pass_R7: assert property (@(posedge clk) disable iff (!srst_n)
    glob_hit |-> (glob_addr[OFFSET_W-1:0] == loc_addr[OFFSET_W-1:0]));

  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!srst_n)
    pg_wr_en |=> (pg_rd_data == $past(pg_wr_data)));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!srst_n)
    !pg_wr_en |=> $stable(pg_rd_data));

endmodule

bind ppm_page_mapper ppm_page_mapper_chk #(
  .LOCAL_AW        (LOCAL_AW),
  .OFFSET_W        (OFFSET_W),
  .PAGE_W          (PAGE_W),
  .LOW_FIXED_PAGE  (LOW_FIXED_PAGE),
  .HIGH_FIXED_PAGE (HIGH_FIXED_PAGE)
) i_chk (
  .clk          (clk),
  .srst_n       (rst_sync_n),
  .loc_addr     (loc_addr),
  .rom_hi_remap (rom_hi_remap),
  .pg_wr_en     (pg_wr_en),
  .pg_wr_data   (pg_wr_data),
  .pg_rd_data   (pg_rd_data),
  .glob_addr    (glob_addr),
  .glob_hit     (glob_hit)
);

// File: tb/test_ppm_page_mapper.sv
module test_ppm_page_mapper;

  localparam time CLK_PERIOD = 10ns;

  logic        clk;
  logic        rst_n;
  logic [15:0] loc_addr;
  logic        rom_hi_remap;
  logic        pg_wr_en;
  logic [7:0]  pg_wr_data;
  logic [7:0]  pg_rd_data;
  logic [21:0] glob_addr;
  logic        glob_hit;

  int total;
  int bad;
  bit done;

  ppm_page_mapper i_ppm_page_mapper (
    .clk          (clk),
    .rst_n        (rst_n),
    .loc_addr     (loc_addr),
    .rom_hi_remap (rom_hi_remap),
    .pg_wr_en     (pg_wr_en),
    .pg_wr_data   (pg_wr_data),
    .pg_rd_data   (pg_rd_data),
    .glob_addr    (glob_addr),
    .glob_hit     (glob_hit)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string rid, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rid, act, exp);
    end
  endtask

  // Expected global address from the window rules
  function automatic logic [21:0] exp_glob(input logic [15:0] a, input logic remap,
                                           input logic [7:0] pg);
    logic [21:0] r;
    if (a < 16'h4000)                 r = '0;
    else if (a < 16'h8000)            r = remap ? 22'h0 : (22'(8'hFD) * 22'h4000 + 22'(a - 16'h4000));
    else if (a < 16'hC000)            r = 22'(pg) * 22'h4000 + 22'(a - 16'h8000);
    else                              r = 22'(8'hFF) * 22'h4000 + 22'(a - 16'hC000);
    return r;
  endfunction

  function automatic logic exp_hit(input logic [15:0] a, input logic remap);
    return (a >= 16'hC000) || (a >= 16'h8000) || (a >= 16'h4000 && !remap);
  endfunction

  function automatic string rid_of(input logic [15:0] a, input logic remap);
    string s;
    if (a < 16'h4000)      s = "R2";
    else if (a < 16'h8000) s = remap ? "R4" : "R3";
    else if (a < 16'hC000) s = "R6";
    else                   s = "R5";
    return s;
  endfunction

  task automatic write_page(input logic [7:0] v, input logic [7:0] old);
    @(negedge clk);
    pg_wr_en   = 1'b1;
    pg_wr_data = v;
    loc_addr   = 16'h8000 | 16'(v) * 16'd37 % 16'h4000;
    #1;
    chk("R8 old page before edge", 32'(glob_addr[21:14]), 32'(old));
    @(negedge clk);
    pg_wr_en = 1'b0;
    #1;
    chk("R8 readback", 32'(pg_rd_data), 32'(v));
    chk("R8 banked new page", 32'(glob_addr), 32'(exp_glob(loc_addr, rom_hi_remap, v)));
    chk("R7 offset", 32'(glob_addr[13:0]), 32'(loc_addr[13:0]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] cur;
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; loc_addr = '0; rom_hi_remap = 1'b0;
    pg_wr_en = 1'b0; pg_wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R1 reset page", 32'(pg_rd_data), 32'h0000_00FE);

    // R10 linear span and full sweep, control low
    for (int a = 0; a < 65536; a++) begin
      loc_addr = 16'(a);
      #1;
      chk(rid_of(16'(a), 1'b0), 32'(glob_hit), 32'(exp_hit(16'(a), 1'b0)));
      if (a >= 16'h4000)
        chk("R10 linear", 32'(glob_addr), 32'h3F4000 + 32'(a - 32'h4000));
      else
        chk("R2 zero addr", 32'(glob_addr), 32'h0);
    end

    // Full sweep with control high
    rom_hi_remap = 1'b1;
    for (int a = 0; a < 65536; a++) begin
      loc_addr = 16'(a);
      #1;
      chk(rid_of(16'(a), 1'b1), 32'(glob_hit), 32'(exp_hit(16'(a), 1'b1)));
      chk(rid_of(16'(a), 1'b1), 32'(glob_addr), 32'(exp_glob(16'(a), 1'b1, 8'hFE)));
    end
    chk("R1 reset page kept", 32'(pg_rd_data), 32'h0000_00FE);

    // All page values, alternating control input
    cur = 8'hFE;
    for (int p = 0; p < 256; p++) begin
      rom_hi_remap = p[0];
      write_page(8'(p), cur);
      cur = 8'(p);
      repeat (2) @(negedge clk);
      #1;
      chk("R9 hold", 32'(pg_rd_data), 32'(cur));
      loc_addr = 16'hC000 | 16'(p) * 16'd61 % 16'h4000;
      #1;
      chk("R5 high fixed", 32'(glob_addr), 32'(exp_glob(loc_addr, rom_hi_remap, cur)));
      loc_addr = 16'h4000 | 16'(p) * 16'd53 % 16'h4000;
      #1;
      chk(rom_hi_remap ? "R4 released" : "R3 low fixed", 32'(glob_addr),
          32'(exp_glob(loc_addr, rom_hi_remap, cur)));
      loc_addr = 16'hBFFF;
      #1;
      chk("R6 banked top", 32'(glob_addr), 32'(exp_glob(16'hBFFF, rom_hi_remap, cur)));
    end

    // Reset again brings page back
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset again", 32'(pg_rd_data), 32'h0000_00FE);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule